// File: doc/BRIEF.md
# Hardware Undo+Redo Transaction Logger

This block sits beside a store path and writes an undo+redo log record for every store whose address falls inside a persistent memory window. A record carries the store address, the data held at that address before the store (taken from the write-allocated cache line), the data being written, and the identifier of the transaction in progress. Records wait in a small on-chip record buffer. The buffer is emptied toward a circular log area in non-volatile memory when a transaction commits, or as soon as the buffer fills up.

The log area is a ring of fixed-size slots. A write pointer (tail) moves forward by one slot for each record the memory port accepts, and wraps from the last slot back to the first. A read pointer (head) is moved forward by an external truncate strobe once recovery software no longer needs the oldest record. When the ring has no free slot, the logger stops writing and holds persistent stores back until space is released. Stores outside the persistent window are accepted at once and never logged.

Top module: `txn_log_engine`

## Requirements
- R1: After reset the record buffer is empty, `log_head` and `log_tail` both equal the ring base `LOG_BASE`, `txid` is 0, `log_stall` is 0 and `mem_wvalid` is 0.
- R2: A store whose address lies outside `[PM_BASE, PM_LIMIT)` is accepted at once (`st_ready` is 1 even during a stall) and produces no memory write.
- R3: A record is presented on `mem_wdata` as 104 bits: store address in bits 103:72, old data in 71:40, new data in 39:8, transaction identifier in 7:0, the identifier being the value of `txid` when the store was accepted.
- R4: Records are written oldest first; each write goes to the slot at `log_tail`, and each accepted write moves `log_tail` forward by `SLOT_BYTES`, wrapping from `LOG_BASE + (LOG_SLOTS-1)*SLOT_BYTES` to `LOG_BASE`.
- R5: Records are written only while a commit is in progress or after the buffer has held `DEPTH` records; otherwise they stay in the buffer and `mem_wvalid` stays 0.
- R6: A persistent store is held back (`st_ready` 0) while the buffer is full or draining or a commit is in progress; every held store is eventually logged and none is dropped.
- R7: When moving `log_tail` one slot would make it equal to `log_head`, `log_stall` is 1, no write is offered and persistent stores get `st_ready` 0; a one-cycle `log_trunc` pulse moves `log_head` forward by one slot (same wrap rule) when head and tail differ.
- R8: A `tx_commit` pulse given after `tx_begin` increments `txid` modulo 256 only after every buffered record has been accepted by the memory port; a `tx_commit` with no open transaction leaves `txid` unchanged.
- R9: While `mem_wvalid` is 1 and `mem_wready` is 0, `mem_wvalid`, `mem_waddr` and `mem_wdata` stay unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store request accepted this cycle when high with st_valid |
| st_addr | input | 32 | Store target address |
| st_new | input | 32 | Data being stored (redo value) |
| st_old | input | 32 | Data previously in the allocated line (undo value) |
| tx_begin | input | 1 | Opens a transaction |
| tx_commit | input | 1 | Commits the open transaction |
| log_trunc | input | 1 | Releases the oldest ring slot |
| mem_wvalid | output | 1 | Log write offered |
| mem_wready | input | 1 | Log write accepted |
| mem_waddr | output | 64 | Byte address of the ring slot being written |
| mem_wdata | output | 104 | Packed log record |
| log_head | output | 64 | Oldest occupied ring slot |
| log_tail | output | 64 | Next free ring slot |
| log_stall | output | 1 | Ring has no free slot |
| txid | output | 8 | Current transaction identifier |

## Verification
The logging path is driven with a short transaction under random memory back-pressure, which separates correct record ordering and packing from mere handshake timing, and with a transaction longer than the buffer while the memory port is held off, which tells a drain started by a full buffer apart from one started by a commit and shows that the extra store is held rather than dropped. A run that fills the ring shows the stall, including a stall that arrives in the middle of a commit so that the identifier must wait for the last record. Stores outside the window, a commit with no open transaction and 256 empty transactions distinguish ignored inputs and identifier wrap from real logging activity.

// File: rtl/txlog_pkg.sv
package txlog_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int TXID_W = 8;
    localparam int PTR_W  = 64;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] undo_val;
        logic [DATA_W-1:0] redo_val;
        logic [TXID_W-1:0] tag;
    } log_rec_t;

    localparam int REC_W = $bits(log_rec_t);

    // Advance a ring pointer by one slot, wrapping at the last slot.
    function automatic logic [PTR_W-1:0] ring_step(
        input logic [PTR_W-1:0] p,
        input logic [PTR_W-1:0] base,
        input int unsigned      slots,
        input int unsigned      slot_bytes
    );
        logic [PTR_W-1:0] last;
        last = base + PTR_W'((slots - 1) * slot_bytes);
        return (p == last) ? base : p + PTR_W'(slot_bytes);
    endfunction

    function automatic logic in_window(
        input logic [ADDR_W-1:0] a,
        input logic [ADDR_W-1:0] lo,
        input logic [ADDR_W-1:0] hi
    );
        return (a >= lo) && (a < hi);
    endfunction

endpackage

// File: rtl/txlog_buf.sv
module txlog_buf
    import txlog_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     push,
    input  log_rec_t rec_in,
    input  logic     pop,
    output log_rec_t rec_out,
    output logic     full,
    output logic     empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    log_rec_t        slots [DEPTH];
    logic [AW-1:0]   rd_idx, wr_idx;
    logic [CW-1:0]   fill;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] i);
        return (i == AW'(DEPTH - 1)) ? '0 : i + AW'(1);
    endfunction

    assign full    = (fill == CW'(DEPTH));
    assign empty   = (fill == '0);
    assign rec_out = slots[rd_idx];

    always_ff @(posedge clk) begin
        if (push) slots[wr_idx] <= rec_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_idx <= '0;
            wr_idx <= '0;
            fill   <= '0;
        end else begin
            if (push) wr_idx <= bump(wr_idx);
            if (pop)  rd_idx <= bump(rd_idx);
            case ({push, pop})
                2'b10:   fill <= fill + CW'(1);
                2'b01:   fill <= fill - CW'(1);
                default: fill <= fill;
            endcase
        end
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/txlog_ring.sv
module txlog_ring
    import txlog_pkg::*;
#(
    parameter logic [63:0] LOG_BASE   = 64'h1000,
    parameter int          LOG_SLOTS  = 16,
    parameter int          SLOT_BYTES = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             trunc,
    output logic [PTR_W-1:0] head,
    output logic [PTR_W-1:0] tail,
    output logic             ring_full
);
    logic [PTR_W-1:0] tail_nx, head_nx;

    assign tail_nx   = ring_step(tail, LOG_BASE, LOG_SLOTS, SLOT_BYTES);
    assign head_nx   = ring_step(head, LOG_BASE, LOG_SLOTS, SLOT_BYTES);
    assign ring_full = (tail_nx == head);

    always_ff @(posedge clk) begin
        if (rst) begin
            head <= LOG_BASE;
            tail <= LOG_BASE;
        end else begin
            if (adv)                   tail <= tail_nx;
            if (trunc && head != tail) head <= head_nx;
        end
    end

    assert_tail_never_meets_head_R7: assert property (@(posedge clk) disable iff (rst)
        adv |=> tail != head);
    assert_no_write_when_full_R7: assert property (@(posedge clk) disable iff (rst)
        ring_full |-> !adv);

endmodule

// File: rtl/txlog_ctrl.sv
module txlog_ctrl
    import txlog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_begin,
    input  logic              tx_commit,
    input  logic              buf_full,
    input  logic              buf_empty,
    output logic              drain,
    output logic              commit_busy,
    output logic [TXID_W-1:0] txid
);
    logic tx_open;
    logic fill_hold;

    assign commit_busy = commit_busy_q;
    logic commit_busy_q;

    assign drain = commit_busy_q | fill_hold | buf_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_open       <= 1'b0;
            commit_busy_q <= 1'b0;
            fill_hold     <= 1'b0;
            txid          <= '0;
        end else begin
            if (buf_full)       fill_hold <= 1'b1;
            else if (buf_empty) fill_hold <= 1'b0;

            if (commit_busy_q && buf_empty) begin
                commit_busy_q <= 1'b0;
                txid          <= txid + TXID_W'(1);
            end else if (tx_commit && tx_open && !commit_busy_q) begin
                commit_busy_q <= 1'b1;
                tx_open       <= 1'b0;
            end else if (tx_begin && !commit_busy_q) begin
                tx_open <= 1'b1;
            end
        end
    end

    assert_txid_steps_by_one_R8: assert property (@(posedge clk) disable iff (rst)
        (txid != $past(txid)) |-> (txid == $past(txid) + TXID_W'(1)));
    assert_txid_after_drain_R8: assert property (@(posedge clk) disable iff (rst)
        (txid != $past(txid)) |-> $past(buf_empty));

endmodule

// File: rtl/txn_log_engine.sv
module txn_log_engine
    import txlog_pkg::*;
#(
    parameter int          DEPTH      = 8,
    parameter logic [63:0] LOG_BASE   = 64'h1000,
    parameter int          LOG_SLOTS  = 16,
    parameter int          SLOT_BYTES = 16,
    parameter logic [31:0] PM_BASE    = 32'h8000_0000,
    parameter logic [31:0] PM_LIMIT   = 32'hC000_0000
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          st_valid,
    output logic                          st_ready,
    input  logic [txlog_pkg::ADDR_W-1:0]  st_addr,
    input  logic [txlog_pkg::DATA_W-1:0]  st_new,
    input  logic [txlog_pkg::DATA_W-1:0]  st_old,
    input  logic                          tx_begin,
    input  logic                          tx_commit,
    input  logic                          log_trunc,
    output logic                          mem_wvalid,
    input  logic                          mem_wready,
    output logic [txlog_pkg::PTR_W-1:0]   mem_waddr,
    output logic [txlog_pkg::REC_W-1:0]   mem_wdata,
    output logic [txlog_pkg::PTR_W-1:0]   log_head,
    output logic [txlog_pkg::PTR_W-1:0]   log_tail,
    output logic                          log_stall,
    output logic [txlog_pkg::TXID_W-1:0]  txid
);
    log_rec_t new_rec, head_rec;
    logic     is_pm, pm_ok, push, pop;
    logic     buf_full, buf_empty, drain, commit_busy, ring_full;

    assign is_pm = in_window(st_addr, PM_BASE, PM_LIMIT);
    assign pm_ok = !drain && !commit_busy && !ring_full && !buf_full;

    assign st_ready = !is_pm || pm_ok;
    assign push     = st_valid && is_pm && pm_ok;

    assign new_rec = '{addr: st_addr, undo_val: st_old, redo_val: st_new, tag: txid};

    assign mem_wvalid = drain && !buf_empty && !ring_full;
    assign pop        = mem_wvalid && mem_wready;
    assign mem_waddr  = log_tail;
    assign mem_wdata  = head_rec;
    assign log_stall  = ring_full;

    txlog_buf #(.DEPTH(DEPTH)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .push    (push),
        .rec_in  (new_rec),
        .pop     (pop),
        .rec_out (head_rec),
        .full    (buf_full),
        .empty   (buf_empty)
    );

    txlog_ring #(
        .LOG_BASE   (LOG_BASE),
        .LOG_SLOTS  (LOG_SLOTS),
        .SLOT_BYTES (SLOT_BYTES)
    ) u_ring (
        .clk       (clk),
        .rst       (rst),
        .adv       (pop),
        .trunc     (log_trunc),
        .head      (log_head),
        .tail      (log_tail),
        .ring_full (ring_full)
    );

    txlog_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .tx_begin    (tx_begin),
        .tx_commit   (tx_commit),
        .buf_full    (buf_full),
        .buf_empty   (buf_empty),
        .drain       (drain),
        .commit_busy (commit_busy),
        .txid        (txid)
    );

    assert_pm_held_on_stall_R7: assert property (@(posedge clk) disable iff (rst)
        (log_stall && st_valid && is_pm) |-> !st_ready);
    assert_plain_store_free_R2: assert property (@(posedge clk) disable iff (rst)
        (st_valid && !is_pm) |-> st_ready);
    assert_write_held_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_wvalid && !mem_wready) |=> (mem_wvalid && $stable(mem_waddr) && $stable(mem_wdata)));
    assert_idle_no_write_R5: assert property (@(posedge clk) disable iff (rst)
        (!drain) |-> !mem_wvalid);

endmodule

// File: tb/txn_log_engine_bench.sv
`timescale 1ns/1ps
module txn_log_engine_bench;
    import txlog_pkg::*;

    localparam logic [63:0] BASE  = 64'h1000;
    localparam int          SLOTS = 16;
    localparam int          SB    = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic              st_valid = 0, st_ready;
    logic [ADDR_W-1:0] st_addr = '0;
    logic [DATA_W-1:0] st_new = '0, st_old = '0;
    logic              tx_begin = 0, tx_commit = 0, log_trunc = 0;
    logic              mem_wvalid, mem_wready = 1'b1;
    logic [PTR_W-1:0]  mem_waddr, log_head, log_tail;
    logic [REC_W-1:0]  mem_wdata;
    logic              log_stall;
    logic [TXID_W-1:0] txid;

    txn_log_engine u_txn_log_engine (
        .clk(clk), .rst(rst), .st_valid(st_valid), .st_ready(st_ready),
        .st_addr(st_addr), .st_new(st_new), .st_old(st_old),
        .tx_begin(tx_begin), .tx_commit(tx_commit), .log_trunc(log_trunc),
        .mem_wvalid(mem_wvalid), .mem_wready(mem_wready), .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata), .log_head(log_head), .log_tail(log_tail),
        .log_stall(log_stall), .txid(txid)
    );

    int checks = 0, errors = 0;
    logic [PTR_W+REC_W-1:0] sb_q [$];
    logic [PTR_W-1:0]  exp_slot = BASE, exp_head = BASE, exp_tail = BASE;
    logic [TXID_W-1:0] exp_txid = '0;
    bit                open_tx = 0, wr_rand = 0;
    logic [15:0]       lfsr = 16'hACE1;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == BASE + PTR_W'((SLOTS - 1) * SB)) ? BASE : p + PTR_W'(SB);
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // random back-pressure on the memory port
    always @(negedge clk) if (wr_rand) begin
        lfsr       = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_wready = lfsr[0] | lfsr[3];
    end

    // monitor: pops the scoreboard on every accepted log write (R3, R4)
    always begin
        @(negedge clk);
        #5;
        if (!rst && mem_wvalid && mem_wready) begin
            if (sb_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R5 actual write %0h expected none", mem_waddr);
            end else begin
                logic [PTR_W+REC_W-1:0] e;
                e = sb_q.pop_front();
                chk("R4 slot", 128'(mem_waddr), 128'(e[PTR_W+REC_W-1:REC_W]));
                chk("R3 record", 128'(mem_wdata), 128'(e[REC_W-1:0]));
                exp_tail = nxt(exp_tail);
            end
        end
    end

    task automatic present(input logic [31:0] a, input logic [31:0] o, input logic [31:0] n);
        @(negedge clk);
        st_valid = 1; st_addr = a; st_old = o; st_new = n;
        #1;
    endtask

    task automatic finish_store();
        while (!st_ready) begin @(negedge clk); #1; end
        if (st_addr >= 32'h8000_0000 && st_addr < 32'hC000_0000) begin
            sb_q.push_back({exp_slot, st_addr, st_old, st_new, exp_txid});
            exp_slot = nxt(exp_slot);
        end
        @(posedge clk); #1;
        st_valid = 0;
    endtask

    task automatic do_store(input logic [31:0] a, input logic [31:0] o, input logic [31:0] n);
        present(a, o, n);
        finish_store();
    endtask

    task automatic begin_tx();
        @(negedge clk); tx_begin = 1;
        @(negedge clk); tx_begin = 0;
        open_tx = 1;
    endtask

    task automatic pulse_commit();
        @(negedge clk); tx_commit = 1;
        @(negedge clk); tx_commit = 0;
        if (open_tx) exp_txid = exp_txid + 8'd1;
        open_tx = 0;
    endtask

    task automatic wait_txid(input string req);
        for (int i = 0; i < 400 && txid !== exp_txid; i++) @(negedge clk);
        #1;
        chk(req, 128'(txid), 128'(exp_txid));
    endtask

    task automatic trunc_one();
        @(negedge clk); log_trunc = 1;
        @(negedge clk); log_trunc = 0; #1;
        if (exp_head != exp_tail) exp_head = nxt(exp_head);
        chk("R7 head after truncate", 128'(log_head), 128'(exp_head));
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual running expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1 reset state
        chk("R1 head", 128'(log_head), 128'(BASE));
        chk("R1 tail", 128'(log_tail), 128'(BASE));
        chk("R1 txid", 128'(txid), 0);
        chk("R1 stall", 128'(log_stall), 0);
        chk("R1 wvalid", 128'(mem_wvalid), 0);

        // R2 store outside the window is accepted at once, never logged
        present(32'h0000_2000, 32'h11, 32'h22);
        chk("R2 ready", 128'(st_ready), 1);
        finish_store();

        // short transaction with random back-pressure
        begin_tx();
        for (int k = 0; k < 3; k++) do_store(32'h8000_0100 + 32'(k * 4), 32'hA0 + 32'(k), 32'hB0 + 32'(k));
        repeat (5) @(negedge clk); #1;
        chk("R5 no write before commit", 128'(mem_wvalid), 0);
        wr_rand = 1;
        pulse_commit();
        wait_txid("R8 txid after commit");
        wr_rand = 0; mem_wready = 1;
        #1;
        chk("R4 tail after drain", 128'(log_tail), 128'(exp_tail));
        repeat (3) trunc_one();

        // buffer fills with memory held off: drain starts without commit, ninth store held
        mem_wready = 0;
        begin_tx();
        for (int k = 0; k < 8; k++) do_store(32'h8000_0200 + 32'(k * 4), 32'hC0 + 32'(k), 32'hD0 + 32'(k));
        present(32'h8000_0300, 32'hEE, 32'hFF);
        chk("R6 ninth store held", 128'(st_ready), 0);
        chk("R5 drain on full buffer", 128'(mem_wvalid), 1);
        @(negedge clk); #1;
        chk("R9 write held stable", 128'(mem_waddr), 128'(exp_tail));
        mem_wready = 1;
        finish_store();
        pulse_commit();
        wait_txid("R8 txid after long transaction");
        chk("R4 tail after wrap region", 128'(log_tail), 128'(exp_tail));
        repeat (9) trunc_one();

        // fill the ring to its limit
        begin_tx();
        for (int k = 0; k < 15; k++) do_store(32'h9000_0000 + 32'(k * 8), 32'(k), 32'(k) ^ 32'hFFFF);
        pulse_commit();
        wait_txid("R8 txid after ring filled");
        chk("R4 tail wrapped", 128'(log_tail), 128'(exp_tail));
        chk("R7 stall raised", 128'(log_stall), 1);
        present(32'h8000_0400, 32'h1, 32'h2);
        chk("R7 pm store held on stall", 128'(st_ready), 0);
        @(negedge clk); st_valid = 0;
        do_store(32'h0000_3000, 32'h3, 32'h4);
        chk("R2 plain store free during stall", 128'(st_ready), 1);
        trunc_one();
        chk("R7 stall released", 128'(log_stall), 0);

        // stall in the middle of a commit: identifier waits for the last record
        begin_tx();
        do_store(32'h8000_0500, 32'h55, 32'h66);
        do_store(32'h8000_0504, 32'h77, 32'h88);
        pulse_commit();
        repeat (10) @(negedge clk); #1;
        chk("R7 no write while ring full", 128'(mem_wvalid), 0);
        chk("R8 txid waits for drain", 128'(txid), 128'(exp_txid - 8'd1));
        trunc_one();
        wait_txid("R8 txid after stalled drain");
        repeat (2) trunc_one();

        // commit without an open transaction
        pulse_commit();
        repeat (6) @(negedge clk); #1;
        chk("R8 commit ignored without begin", 128'(txid), 128'(exp_txid));

        // 256 empty transactions return the identifier to its start
        for (int k = 0; k < 256; k++) begin
            begin_tx();
            pulse_commit();
            for (int i = 0; i < 20 && txid !== exp_txid; i++) @(negedge clk);
        end
        #1;
        chk("R8 txid modulo 256", 128'(txid), 128'(exp_txid));

        repeat (5) @(negedge clk);
        chk("R6 all records written", 128'(sb_q.size()), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule